// File: doc/BRIEF.md
# Glitchless Clock Switchover Multiplexer

This block picks one of two free-running clocks, a primary and a secondary, and drives a single clock output from it. When the select input changes, the output first stops following the outgoing clock. That stop happens on a falling edge of the outgoing clock, so no high pulse is cut short. The output then stays low for a few cycles of the incoming clock before it starts to follow that clock. A source clock may die or stick at a DC level. In that case a force input clears the gating state of the unselected source at once, so the changeover can finish without waiting on edges that will never come.

A conditioning stage follows the gating and acts on the output asynchronously. A power-down input holds the output low. An output enable input, when low, parks the output at a static level chosen by a level-select input. Neither input disturbs the gating state, so the output resumes the current source as soon as both are released. Each source has its own gate controller. The controller is a short shift chain of flops clocked on the falling edge of that source's clock. Each chain only starts filling once the other chain is completely empty.

Top module: `glitchClkSwitch`

## Requirements
- R1: With `selPri` = 1 the output follows `clkPri`, and with `selPri` = 0 it follows `clkSec`, at the period of the chosen source once a changeover has completed. `selPri` must be held steady until a changeover has completed.
- R2: After `selPri` changes, the output shows at most three more rising edges of the outgoing clock. Each of those pulses is full width.
- R3: The two source gates are never open at the same time. While the select is steady and the output is enabled, no high pulse on the output is shorter than half the shorter input period.
- R4: After the outgoing gate closes, the output stays low for at least two full periods of the incoming clock. Its first incoming rising edge comes no later than three outgoing periods plus four incoming periods after the select change.
- R5: While neither source gate is open and the output is enabled and powered, the output is low.
- R6: If the outgoing clock has stopped and `forceSel` is low, the changeover does not complete. The output shows no new rising edge.
- R7: While `forceSel` is high, the gate state of the unselected source is cleared asynchronously. The output stops following that source at once, and the selected source reaches the output within four of its periods.
- R8: While `outEn` is low and `powerDown` is low, the output equals `parkLevel`, asynchronously.
- R9: While `powerDown` is high the output is low, whatever `outEn` and `parkLevel` are. Gate state is kept, so after release the output follows the current source within one of its periods.
- R10: While `rstN` is low both gates are cleared and the output is low. After release the primary reaches the output within four primary periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkPri | input | 1 | Primary clock source, selected by `selPri` = 1 |
| clkSec | input | 1 | Secondary clock source, selected by `selPri` = 0 |
| rstN | input | 1 | Asynchronous active-low reset of both gate chains |
| selPri | input | 1 | Source select: 1 primary, 0 secondary |
| forceSel | input | 1 | Clears the unselected source's gate chain asynchronously |
| outEn | input | 1 | Output enable; low parks the output at `parkLevel` |
| parkLevel | input | 1 | Static output level while disabled |
| powerDown | input | 1 | Holds the output low |
| clkOut | output | 1 | Conditioned switched clock |

## Verification
Two functions can fall in the same cycle. The first is the forced clearing of the dead source's gate. The second is the start of the live source's enable sequence, which R7 expects to begin on the very next falling edge of the live clock. The bench provokes the overlap by freezing the secondary clock high while it drives the output. It then moves the select to the primary and waits, checking that nothing happens, which judges R6. Finally it raises the force input. The judge is the edge log of the output: the output must fall within a nanosecond, and the first primary rising edge must land within four primary periods. The following spacing must then equal the primary period.

// File: rtl/glitchClkPkg.sv
package glitchClkPkg;

  // gate strobes handed from the control to the datapath
  typedef struct packed {
    logic enPri;
    logic enSec;
  } gateStrobe_t;

  localparam int NUM_SRC = 2;
  localparam int IDX_PRI = 1;
  localparam int IDX_SEC = 0;

endpackage

// File: rtl/glitchClkDomain.sv
module glitchClkDomain #(
  parameter int SYNC_STAGES = 3
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic clrIn,
  input  logic reqIn,
  output logic gateEn,
  output logic busy
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;
  logic          clrN;

  // reset and forced clear share the asynchronous clear of the chain
  assign clrN = rstN & ~clrIn;

  // falling-edge chain: the gate only moves while the source clock is low
  always_ff @(negedge clkIn or negedge clrN) begin
    if (!clrN) chain <= '0;
    else       chain <= {chain[LAST-1:0], reqIn};
  end

  assign gateEn = chain[LAST];
  assign busy   = |chain;

endmodule

// File: rtl/glitchClkCtrl.sv
module glitchClkCtrl
  import glitchClkPkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic        clkPri,
  input  logic        clkSec,
  input  logic        rstN,
  input  logic        selPri,
  input  logic        forceSel,
  output gateStrobe_t strobes
);
  logic [NUM_SRC-1:0] srcClk;
  logic [NUM_SRC-1:0] want;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] gate;
  logic [NUM_SRC-1:0] busy;

  assign srcClk[IDX_PRI] = clkPri;
  assign srcClk[IDX_SEC] = clkSec;
  assign want[IDX_PRI]   = selPri;
  assign want[IDX_SEC]   = ~selPri;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dom
    // cross coupling: a source may request only when the other chain is empty
    assign req[i] = want[i] & ~busy[NUM_SRC-1-i];
    assign clr[i] = forceSel & ~want[i];

    glitchClkDomain #(.SYNC_STAGES(SYNC_STAGES)) u_dom (
      .clkIn (srcClk[i]),
      .rstN  (rstN),
      .clrIn (clr[i]),
      .reqIn (req[i]),
      .gateEn(gate[i]),
      .busy  (busy[i])
    );
  end

  assign strobes.enPri = gate[IDX_PRI];
  assign strobes.enSec = gate[IDX_SEC];

  always_comb begin
    AST_ONE_SOURCE: assert (!(strobes.enPri && strobes.enSec)); // R3
  end

  AST_PRI_WAITS: assert property (@(negedge clkPri) disable iff (!rstN)
    $rose(strobes.enPri) |-> !strobes.enSec); // R4

  AST_SEC_WAITS: assert property (@(negedge clkSec) disable iff (!rstN)
    $rose(strobes.enSec) |-> !strobes.enPri); // R4

endmodule

// File: rtl/glitchClkPath.sv
module glitchClkPath
  import glitchClkPkg::*;
(
  input  logic        clkPri,
  input  logic        clkSec,
  input  logic        rstN,
  input  gateStrobe_t strobes,
  input  logic        outEn,
  input  logic        parkLevel,
  input  logic        powerDown,
  output logic        clkOut
);
  logic gatedClk;

  assign gatedClk = (clkPri & strobes.enPri) | (clkSec & strobes.enSec);

  always_comb begin
    if (powerDown)   clkOut = 1'b0;
    else if (!outEn) clkOut = parkLevel;
    else             clkOut = gatedClk;
  end

  AST_PARKED_LOW: assert property (@(posedge clkSec) disable iff (!rstN)
    (!strobes.enPri && !strobes.enSec && outEn && !powerDown) |-> !clkOut); // R5

  AST_DISABLED_LEVEL: assert property (@(posedge clkPri) disable iff (!rstN)
    (!outEn && !powerDown) |-> (clkOut == parkLevel)); // R8

  AST_PD_QUIET: assert property (@(posedge clkPri) disable iff (!rstN)
    powerDown |-> !clkOut); // R9

endmodule

// File: rtl/glitchClkSwitch.sv
module glitchClkSwitch
  import glitchClkPkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic clkPri,
  input  logic clkSec,
  input  logic rstN,
  input  logic selPri,
  input  logic forceSel,
  input  logic outEn,
  input  logic parkLevel,
  input  logic powerDown,
  output logic clkOut
);
  gateStrobe_t strobes;

  glitchClkCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkPri  (clkPri),
    .clkSec  (clkSec),
    .rstN    (rstN),
    .selPri  (selPri),
    .forceSel(forceSel),
    .strobes (strobes)
  );

  glitchClkPath u_path (
    .clkPri   (clkPri),
    .clkSec   (clkSec),
    .rstN     (rstN),
    .strobes  (strobes),
    .outEn    (outEn),
    .parkLevel(parkLevel),
    .powerDown(powerDown),
    .clkOut   (clkOut)
  );

endmodule

// File: tb/glitchClkSwitch_bench.sv
`timescale 1ns/1ps
module glitchClkSwitch_bench;
  localparam real TPRI = 20.0;
  localparam real TSEC = 14.0;

  logic clk = 1'b0;
  logic clkSec = 1'b0;
  logic rstN = 1'b0;
  logic selPri = 1'b1;
  logic forceSel = 1'b0;
  logic outEn = 1'b1;
  logic parkLevel = 1'b0;
  logic powerDown = 1'b0;
  logic clkOut;

  logic secRun = 1'b1;
  logic secLevel = 1'b0;
  logic monOn = 1'b0;

  int total = 0;
  int bad = 0;
  int runts = 0;
  int edgeN = 0;
  int baseN = 0;
  realtime edgeT [0:1023];
  realtime lastRise = 0.0;

  glitchClkSwitch u_glitchClkSwitch (
    .clkPri(clk), .clkSec(clkSec), .rstN(rstN), .selPri(selPri),
    .forceSel(forceSel), .outEn(outEn), .parkLevel(parkLevel),
    .powerDown(powerDown), .clkOut(clkOut)
  );

  always #10 clk = ~clk;

  always begin
    if (secRun) begin
      clkSec = 1'b1; #7;
      clkSec = 1'b0; #7;
    end else begin
      clkSec = secLevel; #1;
    end
  end

  always @(posedge clkOut) begin
    lastRise = $realtime;
    if (edgeN < 1024) begin
      edgeT[edgeN] = $realtime;
      edgeN = edgeN + 1;
    end
  end

  always @(negedge clkOut) begin
    if (monOn && ($realtime - lastRise) < 6.9) runts = runts + 1;
  end

  task automatic check(input string req, input bit ok, input real act, input real exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  task automatic startLog(output realtime mark);
    baseN = edgeN;
    mark = $realtime;
  endtask

  // first edge latency bound and two following spacings
  task automatic checkStart(input string req, input realtime mark, input real tSrc, input real limit);
    if (edgeN < baseN + 3) begin
      check(req, 1'b0, real'(edgeN - baseN), 3.0);
    end else begin
      check(req, (edgeT[baseN] - mark) <= limit, edgeT[baseN] - mark, limit);
      check("R1", (edgeT[baseN+1] - edgeT[baseN] - tSrc) < 0.5 &&
                  (edgeT[baseN] - edgeT[baseN+1] + tSrc) < 0.5,
            edgeT[baseN+1] - edgeT[baseN], tSrc);
      check("R1", (edgeT[baseN+2] - edgeT[baseN+1] - tSrc) < 0.5 &&
                  (edgeT[baseN+1] - edgeT[baseN+2] + tSrc) < 0.5,
            edgeT[baseN+2] - edgeT[baseN+1], tSrc);
    end
  endtask

  task automatic checkSwitch(input realtime mark, input real tOld, input real tNew);
    int k;
    realtime prev;
    k = -1;
    prev = mark;
    for (int i = baseN; i < edgeN; i++) begin
      if (k < 0 && (edgeT[i] - prev) > 30.0) k = i;
      if (k < 0) prev = edgeT[i];
    end
    if (k < 0 || k + 2 >= edgeN) begin
      check("R4", 1'b0, real'(k), 0.0);
    end else begin
      check("R2", (k - baseN) <= 3 && (k - baseN) >= 1, real'(k - baseN), 3.0);
      check("R4", (edgeT[k] - prev) >= (tOld / 2.0 + 2.0 * tNew),
            edgeT[k] - prev, tOld / 2.0 + 2.0 * tNew);
      check("R4", (edgeT[k] - mark) <= (3.0 * tOld + 4.0 * tNew),
            edgeT[k] - mark, 3.0 * tOld + 4.0 * tNew);
      check("R1", (edgeT[k+1] - edgeT[k] - tNew) < 0.5 && (edgeT[k] - edgeT[k+1] + tNew) < 0.5,
            edgeT[k+1] - edgeT[k], tNew);
      check("R1", (edgeT[k+2] - edgeT[k+1] - tNew) < 0.5 && (edgeT[k+1] - edgeT[k+2] + tNew) < 0.5,
            edgeT[k+2] - edgeT[k+1], tNew);
    end
  endtask

  initial begin
    #100us;
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    realtime mark;
    bit expV;

    // R10: output low while reset holds
    #33;
    check("R10", clkOut == 1'b0, real'(clkOut), 0.0);
    #40;
    check("R10", clkOut == 1'b0, real'(clkOut), 0.0);
    startLog(mark);
    rstN = 1'b1;
    monOn = 1'b1;
    #300;
    checkStart("R10", mark, TPRI, 4.0 * TPRI);

    // R1 R2 R4: primary to secondary
    @(negedge clk); #4;
    startLog(mark);
    selPri = 1'b0;
    #400;
    checkSwitch(mark, TPRI, TSEC);

    // R1 R2 R4: secondary to primary, select moved mid high phase
    @(posedge clkSec); #2;
    startLog(mark);
    selPri = 1'b1;
    #400;
    checkSwitch(mark, TSEC, TPRI);

    // back to secondary, then freeze it high
    @(posedge clk); #3;
    selPri = 1'b0;
    #400;
    monOn = 1'b0;
    secLevel = 1'b1;
    secRun = 1'b0;
    #50;
    check("R6", clkOut == 1'b1, real'(clkOut), 1.0);

    // R6: no force, dead source, nothing happens
    startLog(mark);
    selPri = 1'b1;
    #300;
    check("R6", edgeN == baseN, real'(edgeN - baseN), 0.0);
    check("R6", clkOut == 1'b1, real'(clkOut), 1.0);

    // R7: force clears the dead source at once, primary starts
    startLog(mark);
    forceSel = 1'b1;
    #1;
    check("R7", clkOut == 1'b0, real'(clkOut), 0.0);
    #300;
    checkStart("R7", mark, TPRI, 4.0 * TPRI);
    forceSel = 1'b0;
    secLevel = 1'b0;
    secRun = 1'b1;
    #100;

    // R8 R9: sweep of conditioning inputs against both clock phases
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); #2;
      powerDown = c[2];
      outEn     = c[1];
      parkLevel = c[0];
      @(posedge clk); #3;
      expV = c[2] ? 1'b0 : (!c[1] ? c[0] : 1'b1);
      check(c[2] ? "R9" : "R8", clkOut == expV, real'(clkOut), real'(expV));
      @(negedge clk); #3;
      expV = c[2] ? 1'b0 : (!c[1] ? c[0] : 1'b0);
      check(c[2] ? "R9" : "R8", clkOut == expV, real'(clkOut), real'(expV));
    end

    // R9: resume from power-down keeps the gate state
    @(negedge clk); #2;
    powerDown = 1'b1;
    outEn = 1'b1;
    parkLevel = 1'b0;
    #100;
    startLog(mark);
    powerDown = 1'b0;
    #200;
    monOn = 1'b1;
    checkStart("R9", mark, TPRI, TPRI);

    // R3: one more ordinary switch for the runt monitor, then verdict
    @(negedge clk); #7;
    startLog(mark);
    selPri = 1'b0;
    #400;
    checkSwitch(mark, TPRI, TSEC);
    check("R3", runts == 0, real'(runts), 0.0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule